// File: doc/BRIEF.md
# Chainable Delay Trigger Timer

This block holds four delay channels. Each channel has a 32-bit control word and an 11-bit down-counter, and the counter advances only on cycles where a slow time-base strobe `tick` is high (a 2 kHz base in the intended system). A channel runs while its start bit is set. When its count runs out, the channel fires a one-cycle request to a chosen set of eight converter slots. It can then repeat for a programmed number of extra rounds. After the last round it can start any chosen set of delay channels, including itself. Channels can therefore chain into sequences or run as periodic samplers without any software involvement.

Software reaches each control word through one write port. A mode code picks one of three views: a plain write, an OR-in (set) write, or an AND-out (clear) write. The start bit of every channel is visible on `kick_state`.

Top module: `delay_trigger_timer`

## Requirements
- R1: After reset all four control words are zero, `kick_state` is 4'b0000 and `slot_trig` is 8'h00.
- R2: A write that changes bit 20 of a control word from 0 to 1 starts the channel and loads its counter from bits 10:0 (delay D). The channel expires on the D-th later cycle with `tick` high. D=0 behaves as D=1. Cycles with `tick` low do not advance the count.
- R3: When a channel expires, `slot_trig` equals bits 31:24 of its word for the single cycle that follows the expiring clock edge. When nothing expires, `slot_trig` is 8'h00.
- R4: If bits 15:11 (loop count) are non-zero at expiry, the channel decrements them, reloads the delay, keeps running and starts no chained channel.
- R5: On an expiry with loop count zero, bit 20 clears. Every channel j with bit 16+j set is then started with its own delay reloaded. A channel whose own bit is set repeats every D ticks.
- R6: The slot masks of channels that expire on the same edge are ORed together on `slot_trig`.
- R7: `wr_mode` 0 writes `wr_data`, 1 ORs `wr_data` into the word, 2 clears the bits set in `wr_data`, and 3 leaves the word unchanged. `wr_sel` selects the channel.
- R8: A write to a channel overrides that channel's own tick processing and any chained start on the same edge. Writing zero therefore stops the channel at once and produces no trigger.
- R9: `kick_state[i]` shows bit 20 of channel i. A clear write of bit 20 stops a running channel, and it then issues no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Channel whose control word is written |
| wr_mode | input | 2 | 0 plain, 1 set, 2 clear, 3 no-op |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Time-base strobe, one cycle per tick |
| slot_trig | output | 8 | Converter slot trigger pulses |
| kick_state | output | 4 | Start bit of each channel |

## Verification
On every cycle, the assertions check that triggers appear only after a tick and only while some channel was running, that a channel starts only because of a write or a tick, and that writes of zero or no-op writes cannot leave a channel running or change its state. The exact expiry tick, the loop repetitions, the chain ordering, the periodic self-restart and the ORing of masks depend on programmed counts over many cycles. Only the bench's vector table and directed sequences can show these.

// File: rtl/delay_trigger_timer.sv
module delay_trigger_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [1:0]  wr_mode,
  input  logic [31:0] wr_data,
  input  logic        tick,
  output logic [7:0]  slot_trig,
  output logic [3:0]  kick_state
);
  localparam int NCH    = 4;
  localparam int DLY_W  = 11;
  localparam int LOOP_W = 5;
  localparam int KICK_B = 20;
  localparam int LOOP_L = 11;
  localparam int CHN_L  = 16;
  localparam int SLOT_L = 24;

  logic [31:0]      word  [NCH];
  logic [DLY_W-1:0] cnt   [NCH];
  logic [NCH-1:0]   wr_hit, expire, last_exp, chain_go;
  logic [31:0]      new_word;
  logic [7:0]       slot_nxt;

  always_comb begin
    unique case (wr_mode)
      2'd0:    new_word = wr_data;
      2'd1:    new_word = word[wr_sel] | wr_data;
      2'd2:    new_word = word[wr_sel] & ~wr_data;
      default: new_word = word[wr_sel];
    endcase
  end

  always_comb begin
    chain_go = '0;
    slot_nxt = '0;
    for (int i = 0; i < NCH; i++) begin
      wr_hit[i]   = wr_en && (wr_sel == 2'(i));
      expire[i]   = tick && word[i][KICK_B] && !wr_hit[i] && (cnt[i] <= DLY_W'(1));
      last_exp[i] = expire[i] && (word[i][LOOP_L +: LOOP_W] == '0);
      if (last_exp[i]) chain_go = chain_go | word[i][CHN_L +: NCH];
      if (expire[i])   slot_nxt = slot_nxt | word[i][SLOT_L +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_trig <= '0;
      for (int i = 0; i < NCH; i++) begin
        word[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      slot_trig <= slot_nxt;
      for (int i = 0; i < NCH; i++) begin
        if (wr_hit[i]) begin
          word[i] <= new_word;
          if (new_word[KICK_B] && !word[i][KICK_B]) cnt[i] <= new_word[DLY_W-1:0];
        end else begin
          if (expire[i]) begin
            if (!last_exp[i]) begin
              word[i][LOOP_L +: LOOP_W] <= word[i][LOOP_L +: LOOP_W] - 1'b1;
              cnt[i] <= word[i][DLY_W-1:0];
            end else begin
              word[i][KICK_B] <= 1'b0;
            end
          end else if (tick && word[i][KICK_B]) begin
            cnt[i] <= cnt[i] - 1'b1;
          end
          if (chain_go[i]) begin
            word[i][KICK_B] <= 1'b1;
            cnt[i] <= word[i][DLY_W-1:0];
          end
        end
      end
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) kick_state[i] = word[i][KICK_B];

  AST_TRIG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_trig != 8'h00) |-> $past(tick)); // R3
  AST_TRIG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kick_state == 4'b0000) |-> (slot_trig == 8'h00)); // R2
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((kick_state & ~$past(kick_state)) != 4'b0000) |-> $past(wr_en || tick)); // R5
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_mode == 2'd0 && wr_data == 32'd0)
      |-> ((kick_state & (4'b0001 << $past(wr_sel))) == 4'b0000)); // R8
  AST_NOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_mode == 2'd3 && !tick) |-> (kick_state == $past(kick_state))); // R7
endmodule

// File: tb/delay_trigger_timer_tb.sv
`timescale 1ns/1ps
module delay_trigger_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
  logic [1:0] wr_sel = '0, wr_mode = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] slot_trig;
  logic [3:0] kick_state;
  int n_chk = 0, n_bad = 0;
  logic [7:0] last_slot, acc_slot;

  always #2.5 clk = ~clk;

  delay_trigger_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_mode(wr_mode), .wr_data(wr_data), .tick(tick), .slot_trig(slot_trig),
    .kick_state(kick_state));

  // {sel[2], word[32], ticks[8], exp_slot[8], exp_kick[4]}
  localparam logic [53:0] VEC [10] = '{
    {2'd0, 32'h0110_0003, 8'd3,  8'h01, 4'b0000},  // R2 R3
    {2'd0, 32'h0110_0003, 8'd2,  8'h00, 4'b0001},  // R2
    {2'd2, 32'hA510_0000, 8'd1,  8'hA5, 4'b0000},  // R2 zero delay
    {2'd3, 32'h8010_0001, 8'd1,  8'h80, 4'b0000},  // R3
    {2'd1, 32'h3C10_1005, 8'd5,  8'h3C, 4'b0010},  // R4
    {2'd1, 32'h3C10_1005, 8'd15, 8'h3C, 4'b0000},  // R4 final
    {2'd1, 32'h3C10_1005, 8'd14, 8'h00, 4'b0010},  // R4
    {2'd1, 32'h4012_0004, 8'd12, 8'h40, 4'b0010},  // R5 periodic
    {2'd0, 32'h0114_0002, 8'd2,  8'h01, 4'b0100},  // R5 chain
    {2'd0, 32'h0114_0002, 8'd3,  8'h00, 4'b0000}   // R5 chained expiry
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [1:0] mode, logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_mode = mode; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    acc_slot = '0;
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      last_slot = slot_trig;
      acc_slot |= slot_trig;
      tick = 1'b0;
    end
  endtask

  task automatic clear_all();
    for (int c = 0; c < 4; c++) wr(2'(c), 2'd0, 32'd0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 slot", slot_trig, 8'h00);
    chk("R1 kick", kick_state, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 kick after release", kick_state, 4'b0000);

    for (int v = 0; v < 10; v++) begin
      clear_all();
      wr(VEC[v][53:52], 2'd0, VEC[v][51:20]);
      ticks(int'(VEC[v][19:12]));
      chk($sformatf("R3 vec%0d slot", v), last_slot, VEC[v][11:4]);
      chk($sformatf("R9 vec%0d kick", v), kick_state, VEC[v][3:0]);
    end

    // R7 set/clear views, R9 clear stops
    clear_all();
    wr(2'd0, 2'd0, 32'h1100_0002);
    chk("R9 idle", kick_state, 4'b0000);
    wr(2'd0, 2'd1, 32'h0010_0000);
    chk("R7 set kick", kick_state, 4'b0001);
    ticks(1);
    wr(2'd0, 2'd2, 32'h0010_0000);
    chk("R7 clear kick", kick_state, 4'b0000);
    ticks(3);
    chk("R9 no trigger after clear", acc_slot, 8'h00);
    wr(2'd0, 2'd1, 32'h0010_0000);
    ticks(2);
    chk("R7 set kept fields", last_slot, 8'h11);

    // R7 mode 3 ignored
    clear_all();
    wr(2'd2, 2'd3, 32'h0110_0001);
    chk("R7 noop kick", kick_state, 4'b0000);
    ticks(2);
    chk("R7 noop slot", acc_slot, 8'h00);

    // R8 zero write on the same edge as an expiring tick
    clear_all();
    wr(2'd0, 2'd0, 32'h0F10_0001);
    wr_en = 1'b1; wr_sel = 2'd0; wr_mode = 2'd0; wr_data = 32'd0; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R8 no trigger", slot_trig, 8'h00);
    chk("R8 stopped", kick_state, 4'b0000);
    ticks(2);
    chk("R8 still silent", acc_slot, 8'h00);

    // R6 simultaneous expiry
    clear_all();
    wr(2'd0, 2'd0, 32'h0310_0002);
    wr(2'd3, 2'd0, 32'h3010_0002);
    ticks(2);
    chk("R6 ORed slots", last_slot, 8'h33);

    // R4 then R5 chain: ch0 loop 1 chains ch1; gaps without tick hold state
    clear_all();
    wr(2'd1, 2'd0, 32'h0200_0002);
    wr(2'd0, 2'd0, 32'h0112_0801);
    repeat (4) @(negedge clk);
    chk("R2 no tick no expiry", slot_trig, 8'h00);
    ticks(1);
    chk("R4 first round slot", last_slot, 8'h01);
    chk("R4 no chain yet", kick_state, 4'b0001);
    ticks(1);
    chk("R5 final slot", last_slot, 8'h01);
    chk("R5 chain started", kick_state, 4'b0010);
    ticks(1);
    chk("R5 chained counting", last_slot, 8'h00);
    ticks(1);
    chk("R5 chained slot", last_slot, 8'h02);
    chk("R5 all stopped", kick_state, 4'b0000);
    @(negedge clk);
    chk("R3 pulse one cycle", slot_trig, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule